// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Two-Word Buffer

This block is the receive half of an asynchronous serial port. It watches a single input line and samples it at sixteen times the bit rate. It qualifies each start bit and decides every bit by a two-of-three vote around the middle of the bit cell. It assembles characters of 5 to 8 data bits, least significant bit first, with an optional even or odd parity bit.

Each finished character goes into a two-word buffer. Every word carries two tags: one for a parity mismatch and one for a low stop bit. A line break therefore reads back as a framing error on an all-zero character. Software pops words through a read strobe. A small flag register tells software about new data and about characters lost to a full buffer. Each flag can be set by hardware or by a set strobe, cleared by a clear strobe, and masked onto one interrupt line. A two-bit command strobe turns the receiver on and off.

Top module: `serial_rx_tagged`

## Requirements
- R1: The receiver samples the line only while enabled. A pulse on `cmdWr[0]` enables it and a pulse on `cmdWr[1]` disables it, with disable winning when both are pulsed together. It is disabled after reset, and while disabled a complete frame on the line leaves the buffer empty.
- R2: `cfgDataBits` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, sent least significant bit first. `rdData[7:0]` returns the character right-aligned, and the data bits above the configured width read as zero.
- R3: `cfgParity` 2 and 3 select even and odd parity, and 0 or 1 select no parity bit. Parity covers the configured data bits only. A mismatch sets `rdData[14]`, and that bit is always 0 when parity is off.
- R4: `rdData[15]` is set when the first stop bit is sampled low. Only that first stop bit is checked. A break (line held low through the whole frame) reads back as data 0 with `rdData[15]` set.
- R5: A start bit is accepted only if the line is still low at the middle of the bit. A low pulse shorter than half a bit produces no character.
- R6: Each bit is decided by a 2-of-3 majority of samples at the cell centre and its two neighbouring oversample ticks, so a glitch covering one sample does not change the received bit.
- R7: The buffer holds two words and `rdPop` removes the oldest. Bits 13:8 of `rdData` always read 0, and `rdData` is all zero while the buffer is empty. A pop while empty has no effect.
- R8: `rxAvail` is high exactly while at least one word is waiting.
- R9: Flag bit 2 (data valid) is set whenever a word enters the buffer. It drops when a pop empties the buffer or when `flagClr[2]` is pulsed.
- R10: A character that completes while both words are full is discarded, and it sets flag bit 4 (overflow). Bit 4 stays set until `flagClr[4]` is pulsed, and the two stored words are unchanged.
- R11: `flagSet[i]` sets flag i and `flagClr[i]` clears it, with a hardware or software set winning over a clear in the same cycle. `irq` is high when any flag is set whose bit in `flagEn` is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial input line, idle high |
| cmdWr | input | 2 | Command strobes: bit 0 enable, bit 1 disable |
| cfgDataBits | input | 2 | Data width code, 0..3 for 5..8 bits |
| cfgParity | input | 2 | 0/1 none, 2 even, 3 odd |
| rdPop | input | 1 | Pop the oldest buffered word |
| rdData | output | 16 | Oldest word: data [7:0], parity error [14], framing error [15] |
| rxAvail | output | 1 | At least one word is buffered |
| rxOn | output | 1 | Receiver enabled |
| flagSet | input | 5 | Per-bit flag set strobes |
| flagClr | input | 5 | Per-bit flag clear strobes |
| flagEn | input | 5 | Per-bit interrupt enables |
| flagsOut | output | 5 | Flag register: bit 2 data valid, bit 4 overflow |
| irq | output | 1 | Masked OR of the flags |

## Verification
The assertions take three things for granted. The frame configuration only changes while the line is idle. `rdPop` and the command and flag strobes are single-cycle pulses. The line timing matches the oversample rate to within a tick. The stimulus changes configuration only between frames, after an idle gap. It drives every bit cell for exactly sixteen ticks and keeps glitches to one sample wide, so the majority vote and the start check see the conditions they are built for. Expected words are computed in the bench from the data value, the width mask and the parity of the masked bits.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  localparam int RX_MAXB = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;      // new frame accepted
    logic shift;      // data bit decided
    logic parSample;  // parity bit decided
    logic done;       // first stop bit decided
    logic bitVal;     // voted bit value
    logic frmErr;     // stop bit sampled low
  } rxStrobes_t;

  typedef struct packed {
    logic ferr;
    logic perr;
    logic [RX_MAXB-1:0] data;
  } rxWord_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
`timescale 1ns/1ps
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic [1:0] cmdWr,
  input  logic [1:0] cfgDataBits,
  input  logic       parityEn,
  output logic       rxOn,
  output rxStrobes_t strobes
);
  localparam int TW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] SAMP_A = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] SAMP_B = PW'(OVS/2);
  localparam logic [PW-1:0] SAMP_C = PW'(OVS/2 + 1);
  localparam logic [PW-1:0] CELL_END = PW'(OVS - 1);

  logic [1:0] syncQ;
  logic rxS;
  logic [TW-1:0] tickCnt;
  logic tick;
  logic [PW-1:0] phase;
  logic [1:0] votes;
  logic [3:0] bitCnt;
  logic [3:0] nBits;
  logic vote;
  rxState_t state;

  assign rxS   = syncQ[1];
  assign tick  = (tickCnt == TW'(CLKS_PER_TICK - 1));
  assign nBits = 4'd5 + {2'b00, cfgDataBits};
  assign vote  = (votes[0] & votes[1]) | (votes[0] & rxS) | (votes[1] & rxS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      tickCnt <= '0;
      rxOn    <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], rxLine};
      tickCnt <= tick ? '0 : tickCnt + 1'b1;
      if (cmdWr[1])      rxOn <= 1'b0;
      else if (cmdWr[0]) rxOn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      votes   <= 2'b11;
      bitCnt  <= '0;
      strobes <= '0;
    end else begin
      strobes <= '0;
      if (!rxOn) begin
        state <= ST_IDLE;
      end else if (tick) begin
        if (state == ST_IDLE) begin
          if (!rxS) begin
            state <= ST_START;
            phase <= '0;
            strobes.clear <= 1'b1;
          end
        end else begin
          phase <= (phase == CELL_END) ? '0 : phase + 1'b1;
          if (phase == SAMP_A) votes[0] <= rxS;
          if (phase == SAMP_B) votes[1] <= rxS;
          if (phase == SAMP_C) begin
            unique case (state)
              ST_START:  if (vote) state <= ST_IDLE;
              ST_DATA: begin
                strobes.shift  <= 1'b1;
                strobes.bitVal <= vote;
                bitCnt <= bitCnt + 1'b1;
              end
              ST_PARITY: begin
                strobes.parSample <= 1'b1;
                strobes.bitVal    <= vote;
              end
              ST_STOP: begin
                strobes.done   <= 1'b1;
                strobes.frmErr <= !vote;
                state <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (phase == CELL_END) begin
            unique case (state)
              ST_START: begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end
              ST_DATA:   if (bitCnt == nBits) state <= parityEn ? ST_PARITY : ST_STOP;
              ST_PARITY: state <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R1: no frame completes while the receiver is off
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rxOn && !$past(rxOn) |-> !strobes.done);
  // one completion per frame
  p_single_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> !strobes.done);
  // R2: no more shifts than configured bits
  p_bitcnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
endmodule

// File: rtl/serial_rx_datapath.sv
`timescale 1ns/1ps
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int NFLAGS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [1:0]        cfgDataBits,
  input  logic [1:0]        cfgParity,
  input  logic              rdPop,
  output logic [15:0]       rdData,
  output logic              rxAvail,
  input  logic [NFLAGS-1:0] flagSet,
  input  logic [NFLAGS-1:0] flagClr,
  input  logic [NFLAGS-1:0] flagEn,
  output logic [NFLAGS-1:0] flagsOut,
  output logic              irq
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DV_BIT = 2;
  localparam int OF_BIT = 4;

  logic [RX_MAXB-1:0] shReg;
  logic parAcc, parBit;
  rxWord_t mem [DEPTH];
  rxWord_t newWord, head;
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic popAcc, pushAcc, overflow;
  logic [NFLAGS-1:0] hwSet, hwClr;
  logic [3:0] nBits;

  assign nBits   = 4'd5 + {2'b00, cfgDataBits};
  assign newWord.data = shReg >> (4'd8 - nBits);
  assign newWord.perr = cfgParity[1] & (parAcc ^ parBit ^ cfgParity[0]);
  assign newWord.ferr = strobes.frmErr;

  assign popAcc   = rdPop && (count != '0);
  assign pushAcc  = strobes.done && ((count != CW'(DEPTH)) || popAcc);
  assign overflow = strobes.done && !pushAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
      parBit <= 1'b0;
    end else begin
      if (strobes.clear) begin
        shReg  <= '0;
        parAcc <= 1'b0;
      end
      if (strobes.shift) begin
        shReg  <= {strobes.bitVal, shReg[RX_MAXB-1:1]};
        parAcc <= parAcc ^ strobes.bitVal;
      end
      if (strobes.parSample) parBit <= strobes.bitVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pushAcc) begin
        mem[wrPtr] <= newWord;
        wrPtr <= (wrPtr == PTRW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (popAcc) rdPtr <= (rdPtr == PTRW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(pushAcc) - CW'(popAcc);
    end
  end

  assign head    = mem[rdPtr];
  assign rxAvail = (count != '0);
  assign rdData  = rxAvail ? {head.ferr, head.perr, 6'b0, head.data} : 16'h0000;

  always_comb begin
    hwSet = '0;
    hwClr = '0;
    hwSet[DV_BIT] = pushAcc;
    hwSet[OF_BIT] = overflow;
    hwClr[DV_BIT] = popAcc && (count == CW'(1)) && !pushAcc;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                         flagsOut[i] <= 1'b0;
      else if (hwSet[i] || flagSet[i])   flagsOut[i] <= 1'b1;
      else if (hwClr[i] || flagClr[i])   flagsOut[i] <= 1'b0;
    end
  end

  assign irq = |(flagsOut & flagEn);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  p_empty_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdPop && count == CW'(1) && !strobes.done |=> !rxAvail);
  p_dv_on_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushAcc |=> flagsOut[DV_BIT]);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done && count == CW'(DEPTH) && !rdPop |=> flagsOut[OF_BIT] && count == CW'(DEPTH));
  p_of_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut[OF_BIT] && !flagClr[OF_BIT] |=> flagsOut[OF_BIT]);
endmodule

// File: rtl/serial_rx_tagged.sv
`timescale 1ns/1ps
module serial_rx_tagged
  import serial_rx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2,
  parameter int OVS = 16,
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxLine,
  input  logic [1:0]  cmdWr,
  input  logic [1:0]  cfgDataBits,
  input  logic [1:0]  cfgParity,
  input  logic        rdPop,
  output logic [15:0] rdData,
  output logic        rxAvail,
  output logic        rxOn,
  input  logic [4:0]  flagSet,
  input  logic [4:0]  flagClr,
  input  logic [4:0]  flagEn,
  output logic [4:0]  flagsOut,
  output logic        irq
);
  rxStrobes_t strobes;

  serial_rx_ctrl #(.CLKS_PER_TICK(CLKS_PER_TICK), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cmdWr(cmdWr),
    .cfgDataBits(cfgDataBits), .parityEn(cfgParity[1]),
    .rxOn(rxOn), .strobes(strobes)
  );

  serial_rx_datapath #(.DEPTH(DEPTH), .NFLAGS(5)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .rdPop(rdPop), .rdData(rdData), .rxAvail(rxAvail),
    .flagSet(flagSet), .flagClr(flagClr), .flagEn(flagEn),
    .flagsOut(flagsOut), .irq(irq)
  );
endmodule

// File: tb/serial_rx_tagged_tb.sv
`timescale 1ns/1ps
module serial_rx_tagged_tb;
  localparam int CPT = 2;
  localparam int BITCLK = 16 * CPT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic [1:0] cmdWr = '0;
  logic [1:0] cfgDataBits = '0;
  logic [1:0] cfgParity = '0;
  logic rdPop = 1'b0;
  logic [15:0] rdData;
  logic rxAvail, rxOn, irq;
  logic [4:0] flagSet = '0, flagClr = '0, flagEn = '0, flagsOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_rx_tagged #(.CLKS_PER_TICK(CPT), .OVS(16), .DEPTH(2)) u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .cmdWr(cmdWr),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .rdPop(rdPop),
    .rdData(rdData), .rxAvail(rxAvail), .rxOn(rxOn),
    .flagSet(flagSet), .flagClr(flagClr), .flagEn(flagEn),
    .flagsOut(flagsOut), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic driveBit(input logic v);
    rxLine = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  // badPar flips the parity bit, badStop drives the stop bit low
  task automatic sendFrame(input logic [7:0] d, input int nb, input bit badPar, input bit badStop);
    logic p;
    p = 1'b0;
    driveBit(1'b0);
    for (int i = 0; i < nb; i++) begin
      driveBit(d[i]);
      p ^= d[i];
    end
    if (cfgParity[1]) driveBit(p ^ cfgParity[0] ^ badPar);
    driveBit(!badStop);
    rxLine = 1'b1;
    idle(BITCLK);
  endtask

  task automatic pulseCmd(input logic [1:0] c);
    cmdWr = c; @(negedge clk); cmdWr = '0;
  endtask

  task automatic pop();
    rdPop = 1'b1; @(negedge clk); rdPop = 1'b0;
  endtask

  function automatic logic [15:0] expWord(input logic [7:0] d, input int nb,
                                          input logic [1:0] par, input bit badPar, input bit fe);
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    return {fe, (par[1] & badPar), 6'b0, m};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
    logic [1:0] parModes [3] = '{2'd0, 2'd2, 2'd3};
    idle(4);
    rstN = 1'b1;
    idle(2);
    chk("R1 reset off", rxOn, 0);
    chk("R8 reset empty", rxAvail, 0);
    chk("R9 reset flags", flagsOut, 0);
    chk("R7 reset data", rdData, 0);

    // R1: disabled receiver ignores a frame
    sendFrame(8'h55, 8, 0, 0);
    chk("R1 off no data", rxAvail, 0);
    pulseCmd(2'b11);
    chk("R1 disable wins", rxOn, 0);
    pulseCmd(2'b01);
    chk("R1 enabled", rxOn, 1);

    // R2 R3 sweep over widths, parity modes and values
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        cfgDataBits = 2'(w);
        cfgParity = parModes[pm];
        idle(4);
        for (int v = 0; v < 8; v++) begin
          sendFrame(vals[v], w + 5, 0, 0);
          chk("R2 R3 word", rdData, expWord(vals[v], w + 5, cfgParity, 0, 0));
          chk("R8 avail", rxAvail, 1);
          pop();
          chk("R8 empty after pop", rxAvail, 0);
        end
        // parity error injection
        if (cfgParity[1]) begin
          sendFrame(vals[w + 2], w + 5, 1, 0);
          chk("R3 parity error", rdData, expWord(vals[w + 2], w + 5, cfgParity, 1, 0));
          pop();
        end
      end
    end

    // R4 framing error and break
    cfgDataBits = 2'd3; cfgParity = 2'd2;
    idle(4);
    sendFrame(8'h96, 8, 0, 1);
    chk("R4 framing error", rdData, expWord(8'h96, 8, 2'd2, 0, 1));
    pop();
    cfgParity = 2'd0;
    idle(4);
    rxLine = 1'b0;
    idle(BITCLK * 10);
    rxLine = 1'b1;
    idle(BITCLK * 2);
    chk("R4 break word", rdData, 16'h8000);
    pop();

    // R5 short start pulse ignored
    rxLine = 1'b0; idle(3 * CPT); rxLine = 1'b1;
    idle(BITCLK * 12);
    chk("R5 short start ignored", rxAvail, 0);

    // R6 one-sample glitch inside a bit cell
    rxLine = 1'b0; idle(BITCLK);                    // start
    rxLine = 1'b1; idle(18); rxLine = 1'b0; idle(CPT); rxLine = 1'b1; idle(BITCLK - 18 - CPT);
    for (int i = 1; i < 8; i++) begin
      rxLine = i[0]; idle(BITCLK);
    end
    rxLine = 1'b1; idle(BITCLK * 2);
    chk("R6 glitch filtered", rdData, 16'h00AB);
    pop();

    // R7 pop on empty has no effect
    pop();
    chk("R7 empty pop", rxAvail, 0);
    chk("R7 empty pop data", rdData, 0);

    // R9 data-valid flag and irq
    flagClr = 5'h1F; @(negedge clk); flagClr = '0;
    flagEn = 5'b00100;
    sendFrame(8'h11, 8, 0, 0);
    chk("R9 dv set", flagsOut[2], 1);
    chk("R11 irq on dv", irq, 1);
    pop();
    chk("R9 dv drops on empty", flagsOut[2], 0);
    chk("R11 irq low", irq, 0);

    // R10 overflow
    sendFrame(8'h21, 8, 0, 0);
    sendFrame(8'h42, 8, 0, 0);
    sendFrame(8'h84, 8, 0, 0);
    chk("R10 overflow flag", flagsOut[4], 1);
    chk("R10 first kept", rdData, 16'h0021);
    pop();
    chk("R10 second kept", rdData, 16'h0042);
    pop();
    chk("R10 third dropped", rxAvail, 0);
    chk("R10 flag sticky", flagsOut[4], 1);
    flagClr = 5'b10000; @(negedge clk); flagClr = '0;
    chk("R10 flag cleared", flagsOut[4], 0);

    // R11 software set/clear and masking
    flagSet = 5'b00001; @(negedge clk); flagSet = '0;
    chk("R11 sw set", flagsOut, 5'b00001);
    chk("R11 masked", irq, 0);
    flagEn = 5'b00001;
    @(negedge clk);
    chk("R11 enabled irq", irq, 1);
    flagSet = 5'b00010; flagClr = 5'b00011; @(negedge clk); flagSet = '0; flagClr = '0;
    chk("R11 set wins", flagsOut, 5'b00010);
    chk("R11 irq after clear", irq, 0);

    // R1 disable mid-stream
    pulseCmd(2'b10);
    sendFrame(8'h77, 8, 0, 0);
    chk("R1 disabled again", rxAvail, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule